// File: doc/BRIEF.md
# Dual-Channel ATA Interrupt Gate

This block is the host-bus register front end of a two-channel ATA adapter on a simple 8-bit peripheral bus. Each drive channel has its own interrupt-enable latch and an interrupt-control port. Writing that port arms the channel, and reading it disarms the channel. Each channel's raw drive interrupt passes through a synchronizer and can be read as a status bit. The enabled channel's interrupt is forwarded to one host interrupt line. Hardware lets only one channel be armed at a time, so the host can always tell which drive raised the line.

The same address decoder produces chip selects for the two task-file register windows, where registers sit on a 16-byte stride, and for the two alternate-status registers. It also hosts a byte-wide routing register whose bit 0 steers the shared DMA request and acknowledge pair to one channel. A small read-only identification field reports a 4-bit card-type code.

Top module: `ataig_top`

## Requirements
- R1: While reset is asserted, both enables and the routing register are cleared. After reset, `host_irq` and `dma_route` are 0 and a read of address 0x000 returns 0x00.
- R2: A write with any data to 0x880 (channel A) or 0xC80 (channel B) arms that channel and disarms the other channel in the same edge. When read and write strobes arrive together on such an address, the write wins.
- R3: A read of a channel's control address (0x880 or 0xC80) returns 0x00 in the same cycle and disarms that channel at the clock edge. The other channel's enable is left unchanged.
- R4: A read of 0x8A4 (channel A) or 0xCA4 (channel B) returns the synchronized drive interrupt in bit 0, with bits 7..1 zero, whether or not the channel is armed. A change on `drv_intrq` becomes visible two clock edges later.
- R5: `host_irq` is high exactly when some channel is armed and its synchronized interrupt is high.
- R6: During a read or write strobe, address 0x800+16k (channel A) or 0xC00+16k (channel B), for k = 0..7, raises that channel's bit in `tf_cs` (bit 0 = A, bit 1 = B) and drives `tf_reg` = k. Unaligned addresses, and addresses without a strobe, raise no chip select, and `tf_reg` then reads 0.
- R7: During a strobe, address 0x8E0 raises `tf_alt_cs[0]` and address 0xCE0 raises `tf_alt_cs[1]`.
- R8: A write to 0x000 stores the whole byte, a read of 0x000 returns that byte, and `dma_route` follows bit 0 of the stored value (0 = channel A, 1 = channel B).
- R9: A read of 0x2280+4k, for k = 0..3, returns bit k of the card code (default 0x6) in bit 0 with the other bits zero. A read of any unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (14) | Byte address |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| drv_intrq | input | 2 | Raw drive interrupt requests, bit 0 = channel A |
| bus_rdata | output | DATA_W (8) | Read data, valid in the strobe cycle, 0 otherwise |
| host_irq | output | 1 | Gated interrupt to the host |
| tf_cs | output | 2 | Task-file window chip selects |
| tf_reg | output | 3 | Task-file register index |
| tf_alt_cs | output | 2 | Alternate-status register selects |
| dma_route | output | 1 | DMA request/acknowledge steering |

## Verification
On every cycle the assertions check three things: at most one channel is armed, and a control-port write or read leaves exactly the intended enable state one edge later. Control-port reads return zero, and status reads keep their upper bits clear. Chip selects are mutually exclusive, and the routing output follows the last byte written. Some behaviours need the bench's scenarios, which compare against a per-cycle behavioural model. These are the two-edge synchronizer latency, the gating of `host_irq` while a raw interrupt toggles, the full task-file stride sweep with its unaligned neighbours, the identification bits, and the clearing of state by a reset in mid-run.

// File: rtl/ataig_pkg.sv
package ataig_pkg;

   localparam int unsigned NCH        = 2;
   localparam int unsigned MAP_W      = 14;
   localparam int unsigned IDENT_STEP = 4;
   localparam int unsigned IDENT_BITS = 4;

   localparam logic [MAP_W-1:0] ROUTE_ADR  = 14'h0000;
   localparam logic [MAP_W-1:0] IDENT_ADR  = 14'h2280;
   localparam logic [MAP_W-1:0] WIN_ORIGIN = 14'h0800;
   localparam logic [MAP_W-1:0] WIN_PITCH  = 14'h0400;
   localparam logic [MAP_W-1:0] CTL_OFS    = 14'h0080;
   localparam logic [MAP_W-1:0] STAT_OFS   = 14'h00a4;
   localparam logic [MAP_W-1:0] ALT_OFS    = 14'h00e0;

   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_CTL,
      ACC_STAT,
      ACC_TF,
      ACC_ALT,
      ACC_ROUTE,
      ACC_IDENT
   } acc_kind_e;

   typedef struct packed {
      acc_kind_e   kind;
      logic        ch;
      logic [2:0]  idx;
   } acc_t;

   function automatic logic [MAP_W-1:0] win_base(input int unsigned ch);
      return WIN_ORIGIN + MAP_W'(ch) * WIN_PITCH;
   endfunction

   function automatic logic [MAP_W-1:0] ctl_adr(input int unsigned ch);
      return win_base(ch) + CTL_OFS;
   endfunction

   function automatic logic [MAP_W-1:0] stat_adr(input int unsigned ch);
      return win_base(ch) + STAT_OFS;
   endfunction

   function automatic logic [MAP_W-1:0] alt_adr(input int unsigned ch);
      return win_base(ch) + ALT_OFS;
   endfunction

endpackage

// File: rtl/ataig_sync.sv
module ataig_sync #(
   parameter int unsigned W      = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ataig_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("ataig_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) begin
            chain[i] <= '0;
         end
      end else begin
         chain[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) begin
            chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/ataig_decode.sv
module ataig_decode
   import ataig_pkg::*;
#(
   parameter int unsigned ADDR_W      = 14,
   parameter int unsigned REG_N       = 8,
   parameter int unsigned STRIDE_LOG2 = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_t              acc
);

   localparam logic [ADDR_W-1:0] SPAN       = ADDR_W'(REG_N) << STRIDE_LOG2;
   localparam logic [ADDR_W-1:0] ROUTE_A    = ADDR_W'(ROUTE_ADR);
   localparam logic [ADDR_W-1:0] IDENT_A    = ADDR_W'(IDENT_ADR);
   localparam logic [ADDR_W-1:0] IDENT_SPAN = ADDR_W'(IDENT_BITS * IDENT_STEP);
   localparam int unsigned       ISTEP_LOG2 = $clog2(IDENT_STEP);

   generate
      if (REG_N < 1 || REG_N > 8) begin : g_bad_regn
         $error("ataig_decode: REG_N must lie in 1..8");
      end
      if (STRIDE_LOG2 < 1) begin : g_bad_stride
         $error("ataig_decode: STRIDE_LOG2 must be at least 1");
      end
      if ((REG_N << STRIDE_LOG2) > int'(CTL_OFS)) begin : g_bad_span
         $error("ataig_decode: task-file window overlaps control port");
      end
   endgenerate

   logic [NCH-1:0] hit_tf;
   logic [NCH-1:0] hit_ctl;
   logic [NCH-1:0] hit_stat;
   logic [NCH-1:0] hit_alt;
   logic [2:0]     tf_idx [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(win_base(c));
      localparam logic [ADDR_W-1:0] CTLA = ADDR_W'(ctl_adr(c));
      localparam logic [ADDR_W-1:0] STTA = ADDR_W'(stat_adr(c));
      localparam logic [ADDR_W-1:0] ALTA = ADDR_W'(alt_adr(c));

      logic [ADDR_W-1:0] off;
      logic [ADDR_W-1:0] slot;

      assign off         = addr - BASE;
      assign slot        = off >> STRIDE_LOG2;
      assign hit_tf[c]   = (addr >= BASE) && (off < SPAN) &&
                           (off[STRIDE_LOG2-1:0] == '0);
      assign tf_idx[c]   = slot[2:0];
      assign hit_ctl[c]  = (addr == CTLA);
      assign hit_stat[c] = (addr == STTA);
      assign hit_alt[c]  = (addr == ALTA);
   end

   logic [ADDR_W-1:0] id_off;
   logic [ADDR_W-1:0] id_slot;
   logic              hit_ident;

   assign id_off    = addr - IDENT_A;
   assign id_slot   = id_off >> ISTEP_LOG2;
   assign hit_ident = (addr >= IDENT_A) && (id_off < IDENT_SPAN) &&
                      (id_off[ISTEP_LOG2-1:0] == '0);

   always_comb begin
      acc      = '0;
      acc.kind = ACC_NONE;
      for (int c = 0; c < int'(NCH); c++) begin
         if (hit_tf[c]) begin
            acc.kind = ACC_TF;
            acc.ch   = 1'(c);
            acc.idx  = tf_idx[c];
         end else if (hit_ctl[c]) begin
            acc.kind = ACC_CTL;
            acc.ch   = 1'(c);
         end else if (hit_stat[c]) begin
            acc.kind = ACC_STAT;
            acc.ch   = 1'(c);
         end else if (hit_alt[c]) begin
            acc.kind = ACC_ALT;
            acc.ch   = 1'(c);
         end
      end
      if (addr == ROUTE_A) begin
         acc.kind = ACC_ROUTE;
      end else if (hit_ident) begin
         acc.kind = ACC_IDENT;
         acc.idx  = id_slot[2:0];
      end
   end

endmodule

// File: rtl/ataig_ctrl.sv
module ataig_ctrl
   import ataig_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter bit          EXCL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic              wr,
   input  acc_t              acc,
   input  logic [DATA_W-1:0] wdata,
   output logic [NCH-1:0]    chan_en,
   output logic [DATA_W-1:0] route_q
);

   logic arm;
   logic disarm;

   assign arm    = wr && (acc.kind == ACC_CTL);
   assign disarm = rd && !wr && (acc.kind == ACC_CTL);

   generate
      if (EXCL_EN) begin : g_excl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chan_en <= '0;
            end else if (arm) begin
               chan_en         <= '0;
               chan_en[acc.ch] <= 1'b1;
            end else if (disarm) begin
               chan_en[acc.ch] <= 1'b0;
            end
         end
      end else begin : g_indep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chan_en <= '0;
            end else if (arm) begin
               chan_en[acc.ch] <= 1'b1;
            end else if (disarm) begin
               chan_en[acc.ch] <= 1'b0;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_q <= '0;
      end else if (wr && (acc.kind == ACC_ROUTE)) begin
         route_q <= wdata;
      end
   end

endmodule

// File: rtl/ataig_top.sv
module ataig_top
   import ataig_pkg::*;
#(
   parameter int unsigned ADDR_W      = 14,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned REG_N       = 8,
   parameter int unsigned STRIDE_LOG2 = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EXCL_EN     = 1'b1,
   parameter logic [3:0]  CARD_CODE   = 4'h6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [1:0]        drv_intrq,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              host_irq,
   output logic [1:0]        tf_cs,
   output logic [2:0]        tf_reg,
   output logic [1:0]        tf_alt_cs,
   output logic              dma_route
);

   generate
      if (ADDR_W < MAP_W) begin : g_bad_addr
         $error("ataig_top: ADDR_W too narrow for the register map");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("ataig_top: DATA_W must be at least 2");
      end
      if (CARD_CODE == 4'hf) begin : g_bad_code
         $error("ataig_top: code 15 denotes the single-channel variant");
      end
   endgenerate

   acc_t              acc;
   logic [NCH-1:0]    irq_sync;
   logic [NCH-1:0]    chan_en;
   logic [DATA_W-1:0] route_q;
   logic              strobe;

   assign strobe = bus_rd || bus_wr;

   ataig_decode #(
      .ADDR_W      (ADDR_W),
      .REG_N       (REG_N),
      .STRIDE_LOG2 (STRIDE_LOG2)
   ) u_decode (
      .addr (bus_addr),
      .acc  (acc)
   );

   ataig_sync #(
      .W      (NCH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (drv_intrq),
      .q     (irq_sync)
   );

   ataig_ctrl #(
      .DATA_W  (DATA_W),
      .EXCL_EN (EXCL_EN)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd      (bus_rd),
      .wr      (bus_wr),
      .acc     (acc),
      .wdata   (bus_wdata),
      .chan_en (chan_en),
      .route_q (route_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (acc.kind)
            ACC_STAT:  bus_rdata[0] = irq_sync[acc.ch];
            ACC_ROUTE: bus_rdata    = route_q;
            ACC_IDENT: bus_rdata[0] = CARD_CODE[acc.idx[1:0]];
            default:   bus_rdata    = '0;
         endcase
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_sel
      assign tf_cs[c]     = strobe && (acc.kind == ACC_TF)  && (acc.ch == 1'(c));
      assign tf_alt_cs[c] = strobe && (acc.kind == ACC_ALT) && (acc.ch == 1'(c));
   end

   assign tf_reg    = (strobe && (acc.kind == ACC_TF)) ? acc.idx : 3'd0;
   assign host_irq  = |(irq_sync & chan_en);
   assign dma_route = route_q[0];

endmodule

// File: rtl/ataig_chk.sv
module ataig_chk #(
   parameter int unsigned ADDR_W = 14,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              host_irq,
   input logic [1:0]        tf_cs,
   input logic [1:0]        tf_alt_cs,
   input logic              dma_route,
   input logic [1:0]        chan_en
);

   localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(14'h0880);
   localparam logic [ADDR_W-1:0] CTL_B  = ADDR_W'(14'h0c80);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(14'h08a4);
   localparam logic [ADDR_W-1:0] STAT_B = ADDR_W'(14'h0ca4);
   localparam logic [ADDR_W-1:0] ROUTE  = ADDR_W'(14'h0000);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_IDLE: assert (chan_en == 2'b00 && !dma_route && !host_irq); // R1
      end
   end

   AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(chan_en) <= 1); // R2

   AST_ARM_A: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == CTL_A) |=> (chan_en == 2'b01)); // R2

   AST_ARM_B: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == CTL_B) |=> (chan_en == 2'b10)); // R2

   AST_DISARM_A: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == CTL_A) |=> (!chan_en[0] && chan_en[1] == $past(chan_en[1]))); // R3

   AST_CTL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr == CTL_A || bus_addr == CTL_B)) |-> (bus_rdata == '0)); // R3

   AST_STATUS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr == STAT_A || bus_addr == STAT_B)) |-> (bus_rdata[DATA_W-1:1] == '0)); // R4

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en == 2'b00) |-> !host_irq); // R5

   AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tf_cs, tf_alt_cs})); // R6 R7

   AST_CS_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd && !bus_wr) |-> (tf_cs == 2'b00 && tf_alt_cs == 2'b00)); // R6

   AST_ROUTE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ROUTE) |=> (dma_route == $past(bus_wdata[0]))); // R8

   AST_ROUTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == ROUTE) |=> $stable(dma_route)); // R8

endmodule

bind ataig_top ataig_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_rdata (bus_rdata),
   .host_irq  (host_irq),
   .tf_cs     (tf_cs),
   .tf_alt_cs (tf_alt_cs),
   .dma_route (dma_route),
   .chan_en   (chan_en)
);

// File: tb/test_ataig_top.sv
`timescale 1ns/1ps
module test_ataig_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  drv_intrq = '0;
   logic [7:0]  bus_rdata;
   logic        host_irq;
   logic [1:0]  tf_cs;
   logic [2:0]  tf_reg;
   logic [1:0]  tf_alt_cs;
   logic        dma_route;

   always #10 clk = ~clk;

   ataig_top i_ataig_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .drv_intrq (drv_intrq),
      .bus_rdata (bus_rdata),
      .host_irq  (host_irq),
      .tf_cs     (tf_cs),
      .tf_reg    (tf_reg),
      .tf_alt_cs (tf_alt_cs),
      .dma_route (dma_route)
   );

   int n_cmp  = 0;
   int n_fail = 0;
   bit done   = 0;

   // behavioural reference state
   bit   m_en [2];
   bit   m_s1 [2];
   bit   m_s2 [2];
   int   m_route = 0;
   const int CODE = 6;

   task automatic model_reset();
      for (int c = 0; c < 2; c++) begin
         m_en[c] = 0; m_s1[c] = 0; m_s2[c] = 0;
      end
      m_route = 0;
   endtask

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(input string tag, input bit rd, input bit wr,
                       input int addr, input int wd, input bit [1:0] irq);
      int e_rd, e_cs, e_reg, e_alt, e_irq;
      @(negedge clk);
      bus_rd = rd; bus_wr = wr; bus_addr = 14'(addr);
      bus_wdata = 8'(wd); drv_intrq = irq;
      #1;
      e_rd = 0;
      if (rd) begin
         if (addr == 'h8a4) e_rd = m_s2[0];
         else if (addr == 'hca4) e_rd = m_s2[1];
         else if (addr == 'h000) e_rd = m_route;
         else if (addr >= 'h2280 && addr < 'h2290 && addr % 4 == 0)
            e_rd = (CODE >> ((addr - 'h2280) / 4)) & 1;
      end
      e_cs = 0; e_reg = 0; e_alt = 0;
      if (rd || wr) begin
         for (int c = 0; c < 2; c++) begin
            int base = 'h800 + 'h400 * c;
            if (addr >= base && addr < base + 'h80 && addr % 16 == 0) begin
               e_cs  = 1 << c;
               e_reg = (addr - base) / 16;
            end
            if (addr == base + 'he0) e_alt = 1 << c;
         end
      end
      e_irq = (m_en[0] && m_s2[0]) || (m_en[1] && m_s2[1]);
      chk(tag, "bus_rdata", int'(bus_rdata), e_rd);
      chk(tag, "tf_cs", int'(tf_cs), e_cs);
      chk(tag, "tf_reg", int'(tf_reg), e_reg);
      chk(tag, "tf_alt_cs", int'(tf_alt_cs), e_alt);
      chk(tag, "host_irq", int'(host_irq), e_irq);
      chk(tag, "dma_route", int'(dma_route), m_route & 1);
      @(posedge clk);
      #1;
      if (wr && addr == 'h880) begin m_en[0] = 1; m_en[1] = 0; end
      else if (wr && addr == 'hc80) begin m_en[1] = 1; m_en[0] = 0; end
      else if (rd && addr == 'h880) m_en[0] = 0;
      else if (rd && addr == 'hc80) m_en[1] = 0;
      if (wr && addr == 'h000) m_route = wd & 'hff;
      for (int c = 0; c < 2; c++) begin
         m_s2[c] = m_s1[c];
         m_s1[c] = irq[c];
      end
   endtask

   task automatic idle(input string tag, input bit [1:0] irq, input int n);
      for (int i = 0; i < n; i++) step(tag, 0, 0, 'h800, 0, irq);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      idle("R1", 2'b00, 2);
      step("R1", 1, 0, 'h000, 0, 2'b00);
      // R4: raw status with latency, channel disarmed; R5 stays low
      for (int i = 0; i < 3; i++) step("R4", 1, 0, 'h8a4, 0, 2'b01);
      step("R5", 1, 0, 'hca4, 0, 2'b01);
      // R2: arm A with arbitrary data
      step("R2", 0, 1, 'h880, 'h5a, 2'b01);
      idle("R5", 2'b01, 2);
      idle("R5", 2'b10, 3);
      // R2: arm B disarms A
      step("R2", 0, 1, 'hc80, 'hff, 2'b10);
      idle("R5", 2'b10, 2);
      step("R4", 1, 0, 'hca4, 0, 2'b11);
      step("R4", 1, 0, 'h8a4, 0, 2'b11);
      idle("R5", 2'b11, 2);
      // R3: read disarms B, returns zero
      step("R3", 1, 0, 'hc80, 0, 2'b11);
      idle("R3", 2'b11, 2);
      // R3: read of the other port leaves A armed
      step("R2", 0, 1, 'h880, 'h00, 2'b11);
      step("R3", 1, 0, 'hc80, 0, 2'b11);
      idle("R3", 2'b11, 2);
      // R2: both strobes, write wins
      step("R2", 1, 1, 'hc80, 'h11, 2'b01);
      idle("R2", 2'b01, 3);
      // R6: task-file sweep, aligned and unaligned
      for (int c = 0; c < 2; c++) begin
         for (int k = 0; k < 8; k++) begin
            step("R6", 1, 0, 'h800 + 'h400 * c + 16 * k, 0, 2'b00);
            step("R6", 0, 1, 'h800 + 'h400 * c + 16 * k, 'h3c, 2'b00);
            step("R6", 1, 0, 'h800 + 'h400 * c + 16 * k + 4, 0, 2'b00);
         end
         step("R6", 1, 0, 'h800 + 'h400 * c + 'h7f, 0, 2'b00);
      end
      step("R6", 0, 0, 'h840, 0, 2'b00);
      // R7: alternate status
      step("R7", 1, 0, 'h8e0, 0, 2'b00);
      step("R7", 0, 1, 'hce0, 'h02, 2'b00);
      step("R7", 1, 0, 'h8e4, 0, 2'b00);
      // R8: routing register
      step("R8", 0, 1, 'h000, 'h35, 2'b00);
      step("R8", 1, 0, 'h000, 0, 2'b00);
      step("R8", 0, 1, 'h000, 'h02, 2'b00);
      step("R8", 1, 0, 'h000, 0, 2'b00);
      step("R8", 0, 1, 'h000, 'h81, 2'b00);
      idle("R8", 2'b00, 1);
      // R9: identification bits and unmapped reads
      for (int k = 0; k < 4; k++) step("R9", 1, 0, 'h2280 + 4 * k, 0, 2'b00);
      step("R9", 1, 0, 'h2282, 0, 2'b00);
      step("R9", 1, 0, 'h1234, 0, 2'b00);
      // R1: reset in mid-run clears enable and routing
      step("R1", 0, 1, 'h880, 'h01, 2'b11);
      idle("R1", 2'b11, 2);
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      rst_n = 1'b1;
      idle("R1", 2'b11, 3);
      step("R1", 1, 0, 'h000, 0, 2'b11);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

endmodule